// File: doc/BRIEF.md
# Maskable Interrupt Request Generator

This block gathers single-cycle event pulses into a sticky status register and drives one active-low, open-drain interrupt request line. Each status bit has a matching enable bit; the request is active while at least one status bit is set with its enable bit also set. Software acknowledges events by writing ones to the status bits it has serviced. Writing zero to a bit leaves that bit as it is.

Edge-triggered interrupt controllers can miss work that is still pending. This happens when software clears only some of several pending sources, because the line never changes level. The block handles this case: when a clearing write removes some enabled pending bits but leaves others pending, it releases the request for exactly one clock. It then drives the request again, so the controller sees a fresh falling edge. The open-drain pin is modelled as an output enable together with a pin value that is always 0. A separate bus decoder turns register accesses into the clear and enable write strobes.

Top module: `irq_req_gen`

## Requirements
- R1: After reset, the status register and the enable register are all zeros and `irq_oe` is 0.
- R2: A 1 on bit i of `evt_i` at a clock edge sets status bit i at that edge, visible on `status_o` one cycle after the pulse is driven. The bit stays set until it is cleared.
- R3: With `clr_we`=1, each 1 in `clr_data` clears the matching status bit at that edge. Each 0 in `clr_data` leaves its bit unchanged.
- R4: If an event pulse and a clearing write hit the same bit in the same cycle, the event wins and the bit stays set.
- R5: `irq_oe` is 1 exactly when (status AND enable) is nonzero after the edge, except for the cycle named in R7. A status bit whose enable bit is 0 never causes the request.
- R6: With `en_we`=1, `en_data` replaces the enable register at that edge. Enable bit i governs status bit i.
- R7: Two or more enabled status bits may be pending before a clearing write. If that write clears at least one of them and at least one enabled bit is still pending afterwards, `irq_oe` is 0 for exactly one cycle and then returns to 1.
- R8: When a write leaves no enabled bit pending, `irq_oe` goes to 0 on that edge. Clearing only non-enabled bits, or the only pending bit, causes no extra drop.
- R9: `irq_pin` is always 0. The line is pulled low only while `irq_oe` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | WIDTH | Event pulses, one bit per source |
| clr_we | input | 1 | Strobe for a write-one-to-clear status write |
| clr_data | input | WIDTH | Bits to clear (1 = clear) |
| en_we | input | 1 | Strobe for an enable register write |
| en_data | input | WIDTH | New enable register value |
| status_o | output | WIDTH | Current status register |
| enable_o | output | WIDTH | Current enable register |
| irq_oe | output | 1 | Open-drain output enable: 1 pulls the request line low |
| irq_pin | output | 1 | Pin value driven while enabled, always 0 |

## Verification
The bench builds the block with the default WIDTH of 16. This puts both the lowest and the highest source bit under test. The highest bit is used in the partial-clear and collision cases, so an error at the top of the vector would show up. The stimulus also mixes masked and enabled bits within one write, so a wrong decision between a single drop and a plain release would show as a wrong `irq_oe` cycle.

// File: rtl/irq_req_gen.sv
module irq_req_gen #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] evt_i,
  input  logic             clr_we,
  input  logic [WIDTH-1:0] clr_data,
  input  logic             en_we,
  input  logic [WIDTH-1:0] en_data,
  output logic [WIDTH-1:0] status_o,
  output logic [WIDTH-1:0] enable_o,
  output logic             irq_oe,
  output logic             irq_pin
);

  logic [WIDTH-1:0] status_q, enable_q;
  logic [WIDTH-1:0] clr_mask, status_d, enable_d;
  logic [WIDTH-1:0] pend_now, pend_next, pend_hit;
  logic             partial_clr;

  assign clr_mask  = clr_we ? clr_data : '0;
  assign status_d  = (status_q & ~clr_mask) | evt_i;
  assign enable_d  = en_we ? en_data : enable_q;
  assign pend_now  = status_q & enable_q;
  assign pend_next = status_d & enable_d;
  assign pend_hit  = pend_now & clr_mask & ~evt_i;

  assign partial_clr = clr_we && ($countones(pend_now) > 1)
                       && (|pend_hit) && (|pend_next);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      enable_q <= '0;
      irq_oe   <= 1'b0;
    end else begin
      status_q <= status_d;
      enable_q <= enable_d;
      irq_oe   <= (|pend_next) && !partial_clr;
    end
  end

  assign status_o = status_q;
  assign enable_o = enable_q;
  assign irq_pin  = 1'b0;

  assert_evt_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i) |=> ((status_q & $past(evt_i)) == $past(evt_i)));

  assert_hold_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_we && evt_i == '0) |=> $stable(status_q));

  assert_req_needs_pend_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_oe |-> (|(status_q & enable_q)));

  assert_drop_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_oe && (|(status_q & enable_q))) |-> $past(clr_we));

  assert_drop_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_oe && (|(status_q & enable_q)) && !clr_we && !en_we) |=> irq_oe);

endmodule

// File: tb/irq_req_gen_tb.sv
module irq_req_gen_tb;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] evt_i = '0, clr_data = '0, en_data = '0;
  logic         clr_we = 1'b0, en_we = 1'b0;
  logic [W-1:0] status_o, enable_o;
  logic         irq_oe, irq_pin;

  int checks = 0;
  int errors = 0;

  logic [W-1:0] m_st = '0, m_en = '0;
  logic [W-1:0] q_st[$], q_en[$];
  logic         q_oe[$];
  string        q_tag[$];

  always #2.5 clk = ~clk;

  irq_req_gen #(.WIDTH(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .clr_we(clr_we),
    .clr_data(clr_data), .en_we(en_we), .en_data(en_data),
    .status_o(status_o), .enable_o(enable_o), .irq_oe(irq_oe), .irq_pin(irq_pin)
  );

  task automatic check(input string tag, input logic [W-1:0] es, input logic [W-1:0] ee,
                       input logic eo);
    checks++;
    if (status_o !== es || enable_o !== ee || irq_oe !== eo || irq_pin !== 1'b0) begin
      errors++;
      $display("FAIL %s: actual st=%h en=%h oe=%b pin=%b expected st=%h en=%h oe=%b pin=0",
               tag, status_o, enable_o, irq_oe, irq_pin, es, ee, eo);
    end
  endtask

  task automatic step(input logic [W-1:0] ev, input logic cw, input logic [W-1:0] cd,
                      input logic ew, input logic [W-1:0] ed, input string tag);
    logic [W-1:0] pend_old, st_n, en_n;
    logic         drop;
    @(negedge clk);
    evt_i = ev; clr_we = cw; clr_data = cd; en_we = ew; en_data = ed;
    pend_old = m_st & m_en;
    st_n = (m_st & ~(cw ? cd : '0)) | ev;
    en_n = ew ? ed : m_en;
    drop = cw && ($countones(pend_old) > 1) && (|(pend_old & cd & ~ev)) && (|(st_n & en_n));
    m_st = st_n; m_en = en_n;
    q_st.push_back(st_n); q_en.push_back(en_n);
    q_oe.push_back((|(st_n & en_n)) && !drop);
    q_tag.push_back(tag);
    @(posedge clk);
  endtask

  always @(posedge clk) begin
    #1;
    if (q_tag.size() > 0)
      check(q_tag.pop_front(), q_st.pop_front(), q_en.pop_front(), q_oe.pop_front());
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R1 reset state", '0, '0, 1'b0);
    @(negedge clk) rst_n = 1'b1;
    check("R1 after release", '0, '0, 1'b0);

    step(16'h0008, 0, '0, 0, '0, "R2 R5 masked event sets bit");
    step('0, 0, '0, 1, 16'h0008, "R6 enable raises request");
    step('0, 0, '0, 0, '0, "R2 sticky");
    step('0, 1, 16'h0000, 0, '0, "R3 zero write keeps");
    step(16'h8000, 0, '0, 1, 16'h8008, "R5 second source");
    step('0, 1, 16'h0008, 0, '0, "R7 partial clear drops");
    step('0, 0, '0, 0, '0, "R7 reasserts after one cycle");
    step(16'h8000, 1, 16'h8000, 0, '0, "R4 event wins over clear");
    step('0, 1, 16'h8000, 0, '0, "R8 full clear releases");
    step(16'h0003, 0, '0, 1, 16'hFFFF, "R5 two enabled");
    step('0, 1, 16'h0003, 0, '0, "R8 clear all no drop");
    step(16'h0003, 0, '0, 1, 16'h0001, "R6 mixed enable");
    step('0, 1, 16'h0002, 0, '0, "R8 clear masked bit no drop");
    step(16'h8004, 0, '0, 1, 16'h8005, "R5 three pending");
    step('0, 1, 16'h8001, 0, '0, "R7 partial clear high bit");
    step('0, 0, '0, 0, '0, "R7 back high");
    step('0, 0, '0, 1, 16'h0000, "R6 mask all releases");
    step('0, 0, '0, 0, '0, "R9 idle pin low");
    @(negedge clk);
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule